// File: doc/BRIEF.md
# Base-Delta Cache Line Decompressor

This block turns a compressed cache line back into its full 32-byte form. The caller supplies three things: a 4-bit encoding code, a mask that gives one base-select bit per element, and a 32-byte payload assembled from the line's 8-byte storage segments. Each base-delta encoding uses a fixed element width, an explicit base value and one narrow delta per element. The block sign-extends every delta to the element width. Each element then has its own adder, which adds either the explicit base or an implicit zero base to the delta. All elements are rebuilt together in one vector addition, with no serial decoding.

Some codes are not base-delta encodings. The zero code produces an all-zero line. The repeated-value code copies one 8-byte word into every 8-byte lane. The uncompressed code forwards the payload unchanged. Rebuilding a line is purely combinational, and its result is captured in an output register. A line presented with `in_valid` therefore appears one clock later with `out_valid`.

Top module: `delta_line_decomp`

## Requirements
- R1: `out_valid` is low in reset. On every clock edge after reset it takes the value `in_valid` had at that edge, so a line presented in one cycle is on `line_out` in the next cycle. Back-to-back lines are accepted every cycle.
- R2: Code 8 (uncompressed) puts the 32-byte payload on `line_out` unchanged.
- R3: Code 0 (zero line) gives an all-zero `line_out`, whatever the payload and mask are.
- R4: Code 1 (repeated value) copies payload bytes 0..7 into all four 8-byte lanes of `line_out`.
- R5: In a base-delta code with base width B bytes and delta width D bytes, the base is payload bytes 0..B-1 (little-endian). Delta k starts at payload byte B + k*D. Element k is written to `line_out` bytes k*B..k*B+B-1.
- R6: Each delta is treated as a signed two's-complement number and sign-extended to the element width before the add.
- R7: Mask bit k set adds the base to delta k. Mask bit k clear adds zero, so the element equals the sign-extended delta. Mask bits at or above the element count (32/B) have no effect.
- R8: Each element sum wraps modulo 2^(8*B).
- R9: The six base-delta codes are 2: B=8,D=1; 3: B=8,D=2; 4: B=8,D=4; 5: B=4,D=1; 6: B=4,D=2; 7: B=2,D=1.
- R10: Codes 9 to 15 are reserved and give an all-zero `line_out`.
- R11: Payload bytes past the encoding's compressed length (B + (32/B)*D) have no effect. This is the padding up to a whole 8-byte segment or the full line.
- R12: A cycle with `in_valid` low leaves `line_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A compressed line is present this cycle |
| enc_code | input | 4 | Encoding code (see R2-R4, R9, R10) |
| base_sel | input | 16 | Per-element base select; bit k set adds the base to element k |
| payload | input | 256 | Compressed payload, byte 0 in bits 7:0 |
| out_valid | output | 1 | `line_out` holds a freshly rebuilt line |
| line_out | output | 256 | Rebuilt 32-byte line, byte 0 in bits 7:0 |

## Verification
The assertions assume that `enc_code`, `base_sel` and `payload` are known whenever `in_valid` is high. They also assume that these inputs change only between clock edges. The assertions make no assumption about which codes arrive or in what order, so reserved codes and garbage padding are legal inputs. The stimulus drives every input on the falling clock edge. It never leaves an input unknown, holds garbage payload during idle cycles, and runs back-to-back lines across all sixteen codes, including the reserved ones.

// File: rtl/dld_pkg.sv
package dld_pkg;

   typedef enum logic [3:0] {
      ENC_ZERO   = 4'd0,
      ENC_REPEAT = 4'd1,
      ENC_B8D1   = 4'd2,
      ENC_B8D2   = 4'd3,
      ENC_B8D4   = 4'd4,
      ENC_B4D1   = 4'd5,
      ENC_B4D2   = 4'd6,
      ENC_B2D1   = 4'd7,
      ENC_RAW    = 4'd8
   } enc_e;

   localparam int NUM_BD_MODES = 6;
   localparam int FIRST_BD_CODE = 2;
   localparam int REPEAT_BYTES = 8;

   // base width in bytes of base-delta mode i (mode i uses code FIRST_BD_CODE+i)
   function automatic int mode_base(input int i);
      case (i)
         0, 1, 2: return 8;
         3, 4:    return 4;
         default: return 2;
      endcase
   endfunction

   // delta width in bytes of base-delta mode i
   function automatic int mode_delta(input int i);
      case (i)
         0, 3, 5: return 1;
         1, 4:    return 2;
         default: return 4;
      endcase
   endfunction

endpackage

// File: rtl/dld_lane_add.sv
module dld_lane_add #(
   parameter int ELEM_B  = 8,
   parameter int DELTA_B = 1
) (
   input  logic [ELEM_B*8-1:0]  base,
   input  logic [DELTA_B*8-1:0] delta,
   input  logic                 use_base,
   output logic [ELEM_B*8-1:0]  sum
);
   localparam int EW = ELEM_B * 8;
   localparam int DW = DELTA_B * 8;

   if (DELTA_B > ELEM_B || DELTA_B < 1) begin : g_cfg_err
      $error("dld_lane_add: delta wider than element");
   end

   logic [EW-1:0] delta_ext;
   logic [EW-1:0] addend;

   if (DELTA_B == ELEM_B) begin : g_full
      assign delta_ext = delta;
   end else begin : g_sext
      assign delta_ext = {{(EW-DW){delta[DW-1]}}, delta};
   end

   assign addend = use_base ? base : '0;
   assign sum    = addend + delta_ext;

endmodule

// File: rtl/dld_mode_expand.sv
module dld_mode_expand #(
   parameter int LINE_BYTES = 32,
   parameter int BASE_B     = 8,
   parameter int DELTA_B    = 1,
   localparam int N_ELEM    = LINE_BYTES / BASE_B,
   localparam int USED_B    = BASE_B + N_ELEM * DELTA_B
) (
   input  logic [USED_B*8-1:0]     fields,
   input  logic [N_ELEM-1:0]       sel,
   output logic [LINE_BYTES*8-1:0] line
);
   if (LINE_BYTES % BASE_B != 0) begin : g_cfg_div
      $error("dld_mode_expand: line not a multiple of base width");
   end
   if (USED_B > LINE_BYTES) begin : g_cfg_fit
      $error("dld_mode_expand: encoding does not fit in the line");
   end

   logic [BASE_B*8-1:0] base_val;
   assign base_val = fields[BASE_B*8-1:0];

   for (genvar k = 0; k < N_ELEM; k++) begin : g_lane
      dld_lane_add #(
         .ELEM_B (BASE_B),
         .DELTA_B(DELTA_B)
      ) u_lane (
         .base    (base_val),
         .delta   (fields[(BASE_B + k*DELTA_B)*8 +: DELTA_B*8]),
         .use_base(sel[k]),
         .sum     (line[k*BASE_B*8 +: BASE_B*8])
      );
   end

endmodule

// File: rtl/dld_out_select.sv
module dld_out_select #(
   parameter int LINE_BYTES = 32,
   localparam int LW        = LINE_BYTES * 8,
   localparam int MW        = LINE_BYTES / 2
) (
   input  logic [3:0]    enc,
   input  logic [MW-1:0] sel,
   input  logic [LW-1:0] payload,
   output logic [LW-1:0] line
);
   import dld_pkg::*;

   localparam int REP_N = LINE_BYTES / REPEAT_BYTES;

   logic [LW-1:0] bd_line [NUM_BD_MODES];
   logic [LW-1:0] rep_line;
   logic [2:0]    mode_idx;
   logic          is_bd;

   for (genvar i = 0; i < NUM_BD_MODES; i++) begin : g_mode
      localparam int B = mode_base(i);
      localparam int D = mode_delta(i);
      localparam int N = LINE_BYTES / B;
      localparam int U = B + N * D;
      dld_mode_expand #(
         .LINE_BYTES(LINE_BYTES),
         .BASE_B    (B),
         .DELTA_B   (D)
      ) u_mode (
         .fields(payload[U*8-1:0]),
         .sel   (sel[N-1:0]),
         .line  (bd_line[i])
      );
   end

   for (genvar r = 0; r < REP_N; r++) begin : g_rep
      assign rep_line[r*REPEAT_BYTES*8 +: REPEAT_BYTES*8] = payload[REPEAT_BYTES*8-1:0];
   end

   assign is_bd    = (enc >= 4'(FIRST_BD_CODE)) && (enc < 4'(FIRST_BD_CODE + NUM_BD_MODES));
   assign mode_idx = 3'(enc - 4'(FIRST_BD_CODE));

   always_comb begin
      line = '0;
      if (enc == ENC_RAW) begin
         line = payload;
      end else if (enc == ENC_REPEAT) begin
         line = rep_line;
      end else if (is_bd) begin
         line = bd_line[mode_idx];
      end
   end

endmodule

// File: rtl/delta_line_decomp.sv
module delta_line_decomp #(
   parameter int LINE_BYTES = 32,
   localparam int LW        = LINE_BYTES * 8,
   localparam int MW        = LINE_BYTES / 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic [3:0]    enc_code,
   input  logic [MW-1:0] base_sel,
   input  logic [LW-1:0] payload,
   output logic          out_valid,
   output logic [LW-1:0] line_out
);
   if (LINE_BYTES % 8 != 0 || LINE_BYTES < 16) begin : g_cfg_err
      $error("delta_line_decomp: line must be a multiple of 8 bytes, at least 16");
   end

   logic [LW-1:0] line_next;

   dld_out_select #(
      .LINE_BYTES(LINE_BYTES)
   ) u_sel (
      .enc    (enc_code),
      .sel    (base_sel),
      .payload(payload),
      .line   (line_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         line_out  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            line_out <= line_next;
         end
      end
   end

endmodule

// File: rtl/delta_line_decomp_chk.sv
module delta_line_decomp_chk #(
   parameter int LINE_BYTES = 32,
   localparam int LW        = LINE_BYTES * 8,
   localparam int MW        = LINE_BYTES / 2
) (
   input logic          clk,
   input logic          rst_n,
   input logic          in_valid,
   input logic [3:0]    enc_code,
   input logic [MW-1:0] base_sel,
   input logic [LW-1:0] payload,
   input logic          out_valid,
   input logic [LW-1:0] line_out
);
   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid); // R1
   AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid); // R1
   AST_RAW_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && enc_code == 4'd8) |=> (line_out == $past(payload))); // R2
   AST_ZERO_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && enc_code == 4'd0) |=> (line_out == '0)); // R3
   AST_REPEAT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && enc_code == 4'd1) |=> (line_out[63:0] == $past(payload[63:0]))); // R4
   AST_REPEAT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && enc_code == 4'd1) |=> (line_out[LW-1 -: 64] == $past(payload[63:0]))); // R4
   AST_ZERO_BASE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && enc_code == 4'd2 && base_sel[0] == 1'b0)
      |=> (line_out[63:0] == {{56{$past(payload[71])}}, $past(payload[71:64])})); // R7
   AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && enc_code > 4'd8) |=> (line_out == '0)); // R10
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(line_out)); // R12
endmodule

bind delta_line_decomp delta_line_decomp_chk #(.LINE_BYTES(LINE_BYTES)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_valid (in_valid),
   .enc_code (enc_code),
   .base_sel (base_sel),
   .payload  (payload),
   .out_valid(out_valid),
   .line_out (line_out)
);

// File: tb/delta_line_decomp_test.sv
module delta_line_decomp_test;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [3:0]   enc_code = 4'd0;
   logic [15:0]  base_sel = '0;
   logic [255:0] payload = '0;
   logic         out_valid;
   logic [255:0] line_out;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [255:0] exp_q [$];
   string        tag_q [$];
   logic [255:0] last_exp = '0;

   always #4 clk = ~clk; // 125 MHz

   delta_line_decomp uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .enc_code(enc_code),
      .base_sel(base_sel), .payload(payload), .out_valid(out_valid), .line_out(line_out)
   );

   function automatic logic [63:0] low_mask(input int n);
      if (n >= 8) return '1;
      return (64'd1 << (n*8)) - 64'd1;
   endfunction

   function automatic logic [255:0] ref_line(input logic [3:0] code, input logic [15:0] msk,
                                            input logic [255:0] pl);
      logic [255:0] r;
      logic [255:0] sh;
      logic [63:0]  bv, dv, sv;
      int bb, db;
      r = '0; bb = 0; db = 0;
      case (code)
         4'd1: for (int i = 0; i < 4; i++) r[i*64 +: 64] = pl[63:0];
         4'd8: r = pl;
         4'd2: begin bb = 8; db = 1; end
         4'd3: begin bb = 8; db = 2; end
         4'd4: begin bb = 8; db = 4; end
         4'd5: begin bb = 4; db = 1; end
         4'd6: begin bb = 4; db = 2; end
         4'd7: begin bb = 2; db = 1; end
         default: r = '0;
      endcase
      if (bb != 0) begin
         bv = pl[63:0] & low_mask(bb);
         for (int k = 0; k < 32/bb; k++) begin
            sh = pl >> ((bb + k*db)*8);
            dv = sh[63:0] & low_mask(db);
            if (dv[db*8-1]) dv = dv | ~low_mask(db);
            sv = (msk[k] ? bv : 64'd0) + dv;
            for (int b = 0; b < bb; b++) r[(k*bb+b)*8 +: 8] = sv[b*8 +: 8];
         end
      end
      return r;
   endfunction

   task automatic send(input logic [3:0] code, input logic [15:0] msk,
                       input logic [255:0] pl, input string tag);
      @(negedge clk);
      in_valid = 1'b1;
      enc_code = code;
      base_sel = msk;
      payload  = pl;
      exp_q.push_back(ref_line(code, msk, pl));
      tag_q.push_back(tag);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
         enc_code = 4'(i);
         base_sel = 16'hA5A5;
         payload  = {8{$urandom()}};
      end
   endtask

   function automatic logic [255:0] rnd_line();
      logic [255:0] v;
      for (int i = 0; i < 8; i++) v[i*32 +: 32] = $urandom();
      return v;
   endfunction

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         checks++;
         if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL R1: out_valid high with no line pending, actual=1 expected=0");
         end else begin
            logic [255:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            last_exp = e;
            if (line_out !== e) begin
               errors++;
               $display("FAIL %s: actual=%h expected=%h", t, line_out, e);
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [255:0] p;
      repeat (3) @(negedge clk);
      // reset state
      checks++;
      if (out_valid !== 1'b0 || line_out !== '0) begin
         errors++;
         $display("FAIL R1: reset actual=%b/%h expected=0/0", out_valid, line_out);
      end
      rst_n = 1'b1;
      idle(2);

      send(4'd8, 16'h0, rnd_line(), "R2 raw");
      send(4'd0, 16'hFFFF, rnd_line(), "R3 zero");
      send(4'd1, 16'h1234, rnd_line(), "R4 repeat");
      // R5/R9 each base-delta code, all base bits set
      p = rnd_line();
      for (int c = 2; c <= 7; c++) send(4'(c), 16'hFFFF, p, "R9 mode all-base");
      // R6 negative delta: base 0x100, delta 0x80 -> 0x80
      p = '0; p[63:0] = 64'h100; p[71:64] = 8'h80; p[79:72] = 8'h7F;
      send(4'd2, 16'h000F, p, "R6 sign extend");
      // R7 mixed mask and ignored upper mask bits
      send(4'd7, 16'h5A5A, rnd_line(), "R7 mixed mask");
      p = rnd_line();
      send(4'd2, 16'hFFF0, p, "R7 upper mask ignored");
      send(4'd2, 16'h0000, p, "R7 zero base");
      // R8 wrap: B4D1 base all ones plus delta 1
      p = '0; p[31:0] = 32'hFFFF_FFFF; for (int k = 0; k < 8; k++) p[(4+k)*8 +: 8] = 8'h01;
      send(4'd5, 16'h00FF, p, "R8 wrap");
      // R10 reserved
      send(4'd9, 16'hFFFF, rnd_line(), "R10 reserved");
      send(4'd15, 16'hFFFF, rnd_line(), "R10 reserved");
      // R11 padding: B8D2 uses 16 bytes; two payloads differ only above
      p = rnd_line();
      send(4'd3, 16'h000A, p, "R11 padding A");
      p[255:128] = ~p[255:128];
      send(4'd3, 16'h000A, p, "R11 padding B");
      idle(1);
      // R12 hold over idle cycles with garbage inputs
      idle(3);
      checks++;
      if (out_valid !== 1'b0 || line_out !== last_exp) begin
         errors++;
         $display("FAIL R12: actual=%b/%h expected=0/%h", out_valid, line_out, last_exp);
      end
      // R1 back-to-back random traffic over all codes
      for (int n = 0; n < 300; n++) begin
         send(4'($urandom_range(0, 15)), 16'($urandom()), rnd_line(), "R1 random");
         if (n % 37 == 0) idle(1);
      end
      idle(3);
      checks++;
      if (exp_q.size() != 0) begin
         errors++;
         $display("FAIL R1: pending lines actual=%0d expected=0", exp_q.size());
      end
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule